// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block produces the access address for one port of a banked memory. The address has two fields, a bank number and a word within the bank, and the block treats them as one binary count. In every clock cycle the block does one of four things. It passes through an externally supplied start address, steps one past the address used in the previous cycle, reuses that previous address, or returns to the most recent start address it captured. The chosen address appears combinationally on the outputs for the current cycle and is registered as the base for the next cycle.

All controls are active low and take effect at the rising edge of the clock. The repeat control has the highest priority, then the load strobe, then the count enable. With none of them asserted, the block holds. A count that runs off the last word of a bank carries into the next bank, and the last word of the last bank wraps to bank 0, word 0. Chip enables and byte enables have no part in this block, so a burst keeps counting while the memory port is deselected. The captured start address has no meaningful value until the first load. Asserting repeat before any load leaves the address unchanged and raises an error flag for that cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, the base register clears to bank 0, word 0, and the captured start address is marked empty. After reset, a cycle with all controls high gives `acc_bank`=0, `acc_word`=0 and `rpt_err`=0.
- R2: In a cycle with `load_n`=0 and `repeat_n`=1, `acc_bank`/`acc_word` equal `ext_bank`/`ext_word` in that same cycle.
- R3: In a cycle with `repeat_n`=1, `load_n`=1 and `cnt_en_n`=0, the output is one more than the previous cycle's output. The count is formed as {bank, word}, with the bank in the upper bits.
- R4: In a cycle with all three controls high, the output equals the previous cycle's output, and `ext_bank`/`ext_word` have no effect.
- R5: In a cycle with `repeat_n`=0, once a start address has been captured, the output equals the last captured start address whatever `load_n`, `cnt_en_n` and the external address are. Such a cycle does not update the captured address.
- R6: Advancing from word 2^WORD_W-1 of bank b gives word 0 of bank b+1.
- R7: Advancing from word 2^WORD_W-1 of bank 2^BANK_W-1 gives bank 0, word 0.
- R8: Every load cycle (R2) replaces the captured start address, so a later repeat returns the most recent load.
- R9: In a cycle with `repeat_n`=0 and no load since reset, `rpt_err`=1 and the output equals the previous cycle's output. In all other cycles `rpt_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low strobe: use and capture the external address |
| cnt_en_n | input | 1 | Active-low count enable: step the address by one |
| repeat_n | input | 1 | Active-low repeat: return to the captured start address |
| ext_bank | input | BANK_W | External bank number |
| ext_word | input | WORD_W | External word address within the bank |
| acc_bank | output | BANK_W | Bank number of the current access |
| acc_word | output | WORD_W | Word address of the current access |
| rpt_err | output | 1 | High in a cycle where repeat is asserted before any load |

## Verification
A corrupted base register shows at the outputs in the very next hold or advance cycle, because those cycles expose the base register directly or plus one. A bad carry between the word and bank fields shows only at a bank boundary, so bursts are started on the last word of a middle bank and of the last bank. A corrupted captured start address stays hidden until a repeat cycle. The tests therefore use a repeat after loads, after advances, and in a cycle where a competing load is ignored, which also shows whether that competing load was wrongly captured.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_ADV  = 2'd1,
    OP_LOAD = 2'd2,
    OP_RPT  = 2'd3
  } bac_op_e;
endpackage

// File: rtl/bac_op_decode.sv
module bac_op_decode
  import bac_pkg::*;
(
  input  logic    load_n,
  input  logic    cnt_en_n,
  input  logic    repeat_n,
  input  logic    rpt_valid,
  output bac_op_e op,
  output logic    rpt_err
);
  // Priority: repeat, strobe, count enable, hold.
  always_comb begin
    rpt_err = 1'b0;
    if (!repeat_n) begin
      if (rpt_valid) begin
        op = OP_RPT;
      end else begin
        op      = OP_HOLD;
        rpt_err = 1'b1;
      end
    end else if (!load_n) begin
      op = OP_LOAD;
    end else if (!cnt_en_n) begin
      op = OP_ADV;
    end else begin
      op = OP_HOLD;
    end
  end
endmodule

// File: rtl/bac_repeat_store.sv
module bac_repeat_store
  import bac_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bac_op_e       op,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] rpt_addr,
  output logic          rpt_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_addr  <= '0;
      rpt_valid <= 1'b0;
    end else if (op == OP_LOAD) begin
      rpt_addr  <= ext_addr;
      rpt_valid <= 1'b1;
    end
  end

  AST_CAPTURE_LAST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (rpt_valid && rpt_addr == $past(ext_addr))); // R8

  AST_REPEAT_KEEPS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RPT) |=> $stable(rpt_addr)); // R5
endmodule

// File: rtl/bac_counter.sv
module bac_counter
  import bac_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bac_op_e       op,
  input  logic [AW-1:0] ext_addr,
  input  logic [AW-1:0] rpt_addr,
  output logic [AW-1:0] acc_addr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] base_q;
  logic          past_ok;

  // Full-width add: word overflow carries into the bank field,
  // and the top bank wraps to zero.
  always_comb begin
    unique case (op)
      OP_LOAD: acc_addr = ext_addr;
      OP_ADV:  acc_addr = base_q + ONE;
      OP_RPT:  acc_addr = rpt_addr;
      default: acc_addr = base_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      past_ok <= 1'b0;
    end else begin
      base_q  <= acc_addr;
      past_ok <= 1'b1;
    end
  end

  AST_ADVANCE_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && op == OP_ADV) |-> (acc_addr == $past(acc_addr) + ONE)); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && op == OP_HOLD) |-> (acc_addr == $past(acc_addr))); // R4
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bac_pkg::*;
#(
  parameter int BANK_W = 6,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              cnt_en_n,
  input  logic              repeat_n,
  input  logic [BANK_W-1:0] ext_bank,
  input  logic [WORD_W-1:0] ext_word,
  output logic [BANK_W-1:0] acc_bank,
  output logic [WORD_W-1:0] acc_word,
  output logic              rpt_err
);
  localparam int AW = BANK_W + WORD_W;

  bac_op_e       op;
  logic          rpt_valid;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] rpt_addr;
  logic [AW-1:0] acc_addr;
  logic          past_ok;

  assign ext_addr = {ext_bank, ext_word};

  bac_op_decode u_decode (
    .load_n    (load_n),
    .cnt_en_n  (cnt_en_n),
    .repeat_n  (repeat_n),
    .rpt_valid (rpt_valid),
    .op        (op),
    .rpt_err   (rpt_err)
  );

  bac_repeat_store #(.AW(AW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .ext_addr  (ext_addr),
    .rpt_addr  (rpt_addr),
    .rpt_valid (rpt_valid)
  );

  bac_counter #(.AW(AW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .ext_addr (ext_addr),
    .rpt_addr (rpt_addr),
    .acc_addr (acc_addr)
  );

  assign acc_bank = acc_addr[AW-1:WORD_W];
  assign acc_word = acc_addr[WORD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_LOAD_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && repeat_n) |-> ({acc_bank, acc_word} == {ext_bank, ext_word})); // R2

  AST_REPEAT_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (!repeat_n && rpt_valid) |-> (acc_addr == rpt_addr)); // R5

  AST_ERR_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rpt_err) |-> (acc_addr == $past(acc_addr))); // R9

  AST_ERR_NEEDS_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_err |-> !repeat_n); // R9
endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
  localparam int BW = 6;
  localparam int WW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_n = 1'b1;
  logic          cnt_en_n = 1'b1;
  logic          repeat_n = 1'b1;
  logic [BW-1:0] ext_bank = '0;
  logic [WW-1:0] ext_word = '0;
  logic [BW-1:0] acc_bank;
  logic [WW-1:0] acc_word;
  logic          rpt_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_gen #(.BANK_W(BW), .WORD_W(WW)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (load_n),
    .cnt_en_n (cnt_en_n),
    .repeat_n (repeat_n),
    .ext_bank (ext_bank),
    .ext_word (ext_word),
    .acc_bank (acc_bank),
    .acc_word (acc_word),
    .rpt_err  (rpt_err)
  );

  // Apply controls after a falling edge; outputs are read 2 ns later.
  task automatic drive(input logic ld, input logic ce, input logic rp,
                       input int b, input int w);
    @(negedge clk);
    load_n   = ld;
    cnt_en_n = ce;
    repeat_n = rp;
    ext_bank = BW'(b);
    ext_word = WW'(w);
    #2;
  endtask

  task automatic chk(input string req, input int eb, input int ew, input bit ee);
    n_chk++;
    if (acc_bank !== BW'(eb) || acc_word !== WW'(ew) || rpt_err !== ee) begin
      n_bad++;
      $display("FAIL %s: got bank=%0d word=%h err=%0b, expected bank=%0d word=%h err=%0b",
               req, acc_bank, acc_word, rpt_err, eb, ew, ee);
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    drive(1, 1, 1, 7, 'h3A5);
    drive(1, 1, 1, 7, 'h3A5);
    rst_n = 1'b1;
    drive(1, 1, 1, 9, 'h111);
    chk("R1 idle after reset", 0, 0, 0);
  endtask

  task automatic t_repeat_unloaded();
    drive(1, 0, 1, 0, 0);
    chk("R3 step from reset base", 0, 1, 0);
    drive(1, 1, 0, 4, 'h44);
    chk("R9 repeat before load", 0, 1, 1);
    drive(1, 1, 1, 4, 'h44);
    chk("R9 flag clears", 0, 1, 0);
  endtask

  task automatic t_load_hold_adv();
    drive(0, 1, 1, 3, 'h123);
    chk("R2 load passes through", 3, 'h123, 0);
    drive(1, 1, 1, 50, 'hABC);
    chk("R4 hold ignores ext", 3, 'h123, 0);
    drive(1, 0, 1, 50, 'hABC);
    chk("R3 advance 1", 3, 'h124, 0);
    drive(1, 0, 1, 1, 1);
    chk("R3 advance 2", 3, 'h125, 0);
    drive(1, 1, 0, 1, 1);
    chk("R9 no error after load", 3, 'h123, 0);
  endtask

  task automatic t_bank_carry();
    drive(0, 0, 1, 5, 'hFFF);
    chk("R2 load with count low", 5, 'hFFF, 0);
    drive(1, 0, 1, 0, 0);
    chk("R6 carry into next bank", 6, 0, 0);
  endtask

  task automatic t_top_wrap();
    drive(0, 1, 1, 63, 'hFFE);
    chk("R2 load near top", 63, 'hFFE, 0);
    drive(1, 0, 1, 0, 0);
    chk("R3 advance near top", 63, 'hFFF, 0);
    drive(1, 0, 1, 0, 0);
    chk("R7 wrap to bank 0", 0, 0, 0);
  endtask

  task automatic t_repeat_priority();
    drive(0, 1, 1, 10, 'h200);
    drive(1, 0, 1, 0, 0);
    drive(1, 0, 1, 0, 0);
    chk("R3 burst before repeat", 10, 'h202, 0);
    drive(0, 0, 0, 1, 1);
    chk("R5 repeat beats load and count", 10, 'h200, 0);
    drive(1, 0, 1, 1, 1);
    chk("R5 count resumes from start", 10, 'h201, 0);
    drive(1, 1, 0, 1, 1);
    chk("R5 competing load not captured", 10, 'h200, 0);
  endtask

  task automatic t_reload_updates();
    drive(0, 1, 1, 20, 'h050);
    drive(1, 0, 1, 0, 0);
    drive(1, 0, 1, 0, 0);
    drive(1, 1, 0, 0, 0);
    chk("R8 repeat returns newest load", 20, 'h050, 0);
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst_n = 1'b0;
    drive(1, 1, 1, 0, 0);
    rst_n = 1'b1;
    drive(1, 1, 1, 0, 0);
    chk("R1 reset clears base", 0, 0, 0);
    drive(1, 1, 0, 0, 0);
    chk("R9 reset forgets start address", 0, 0, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset_state();
    t_repeat_unloaded();
    t_load_hold_adv();
    t_bank_carry();
    t_top_wrap();
    t_repeat_priority();
    t_reload_updates();
    t_reset_again();
    finish_run();
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end
endmodule